// File: doc/BRIEF.md
# Dual-Source Serial Bit-Rate Strobe Generator

This block makes the receive and transmit bit-rate strobes for an 8051-style serial port. It has two sources. The first is a 16-bit timer that reloads itself on overflow. It advances at half the core clock, or on falling edges of an external count pin. The second is the overflow pulse of a neighbouring 8-bit timer. That pulse is halved unless a double-rate bit is set. Each direction picks its own source, and the chosen overflow stream is divided by sixteen. The result is one single-cycle enable per serial bit, so receive and transmit can run at different rates at the same time.

A falling edge on a trigger pin can also set a sticky interrupt flag while the block runs as a bit-rate generator. The edge never causes a reload or a capture. Software loads the block through a small byte-wide write port.

With the internal clock, a reload value R gives one bit strobe every 32 × (65536 − R) core cycles.

Top module: `baudgen_top`

## Requirements
- R1: With `run`=1 and count source 0, the 16-bit timer advances once every two core cycles. A direction routed to it produces one bit strobe every 32 × (65536 − R) cycles.
- R2: On overflow, the timer restarts from the reload value R, so successive strobe intervals are all equal. While `run`=0, the timer is held at R.
- R3: Each bit strobe (`rx_bit_en`, `tx_bit_en`) is high for exactly one core cycle. It comes once per 16 overflows of the selected source.
- R4: Control bit 2 (rx select) set routes receive to the reload timer. When it is clear, receive uses the neighbouring timer's path.
- R5: Control bit 3 (tx select) routes transmit in the same way, independently of receive. The two strobes can run at different rates at the same time.
- R6: On the neighbouring-timer path, every second `t1_ovf` pulse is passed on when control bit 5 (double rate) is 0. Every pulse is passed on when it is 1. With one `t1_ovf` every P cycles, the strobe interval is 32·P or 16·P.
- R7: With control bit 0 (run) clear, the reload timer does not count, and a direction routed to it gives no strobes.
- R8: With control bit 1 (count source) set, the timer advances once per falling edge of `count_pin`, seen through a two-flop synchronizer. With R=0xFFFF, 32 falling edges give exactly 2 strobes.
- R9: A falling edge on `trig_pin` sets `ext_flag` when control bit 4 (trigger enable) is 1. The edge is ignored when that bit is 0.
- R10: `ext_flag` stays set until a write to address 3. If a new edge and the clear write arrive in the same cycle, the edge wins.
- R11: Synchronous active-high `rst` clears the timer, the prescaler, both dividers and `ext_flag`. After reset, no strobes occur.
- R12: At a 16.777216 MHz core clock, R=0xFFC9 gives a 1760-cycle interval (about 9532 baud). R=0xFFE5 gives 864 cycles (about 19418 baud).
- R13: The write port (`wr_en`, `wr_addr`, `wr_data`) uses address 0 for the low reload byte, address 1 for the high reload byte, address 2 for control (bits 0 to 5 as above) and address 3 to clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 2 | Write address (0 reload low, 1 reload high, 2 control, 3 clear flag) |
| wr_data | input | 8 | Write data byte |
| t1_ovf | input | 1 | One-cycle overflow pulse from the neighbouring 8-bit timer |
| count_pin | input | 1 | External count input, asynchronous |
| trig_pin | input | 1 | External trigger input, asynchronous |
| rx_bit_en | output | 1 | Receive bit-rate enable pulse |
| tx_bit_en | output | 1 | Transmit bit-rate enable pulse |
| ext_flag | output | 1 | Sticky trigger flag, used as the interrupt request |

## Verification
The in-line assertions check, on every cycle, the local invariants:
- an overflow always leaves the timer at the reload value;
- a halted timer never overflows;
- overflow pulses and edge pulses never occur on back-to-back cycles;
- a divider strobe coincides with its count wrapping to zero;
- the flag rises only after an enabled trigger edge and holds until a clear write.

Only the directed scenarios can show the end-to-end behaviour:
- the exact strobe spacing for given reload values;
- the independent per-direction routing;
- the halving on the neighbouring-timer path;
- the count of strobes produced from external pin edges.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    localparam int TMR_W       = 16;
    localparam int DIV_BITS    = 4;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_CH      = 2;

    typedef enum logic [1:0] {
        ADDR_RLD_LO = 2'd0,
        ADDR_RLD_HI = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_CLR    = 2'd3
    } waddr_e;

    // Control byte; first member is the MSB.
    typedef struct packed {
        logic [1:0] spare;
        logic       dbl;
        logic       trig_en;
        logic       tx_sel;
        logic       rx_sel;
        logic       cnt_src;
        logic       run;
    } ctrl_t;

    function automatic logic pick_src(input logic sel, input logic tmr, input logic other);
        return sel ? tmr : other;
    endfunction

endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = last_q & ~sync_q[STAGES-1];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R8

endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         ext_mode_i,
    input  logic         ext_fall_i,
    input  logic [W-1:0] reload_i,
    output logic         ovf_o
);
    logic         pre_q;
    logic [W-1:0] cnt_q;
    logic         ovf_q;
    logic         inc;
    logic         at_top;

    assign at_top = &cnt_q;
    assign inc    = run_i && (ext_mode_i ? ext_fall_i : pre_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= 1'b0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (!run_i) begin
            pre_q <= 1'b0;
            cnt_q <= reload_i;
            ovf_q <= 1'b0;
        end else begin
            pre_q <= ext_mode_i ? 1'b0 : ~pre_q;
            ovf_q <= inc && at_top;
            if (inc) begin
                cnt_q <= at_top ? reload_i : cnt_q + 1'b1;
            end
        end
    end

    assign ovf_o = ovf_q;

    AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (cnt_q == $past(reload_i))); // R2
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !ovf_q); // R7
    AST_OVF_SPACED: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> !ovf_q); // R1

endmodule

// File: rtl/baud_div.sv
module baud_div #(
    parameter int BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic strobe_o
);
    logic [BITS-1:0] cnt_q;
    logic            strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= tick_i && (&cnt_q);
            if (tick_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign strobe_o = strobe_q;

    AST_STROBE_WRAP: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> (cnt_q == '0)); // R3

endmodule

// File: rtl/baudgen_top.sv
module baudgen_top
    import baudgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       t1_ovf,
    input  logic       count_pin,
    input  logic       trig_pin,
    output logic       rx_bit_en,
    output logic       tx_bit_en,
    output logic       ext_flag
);
    localparam int BYTES = TMR_W / 8;

    logic [TMR_W-1:0] reload_q;
    ctrl_t            ctrl_q;
    logic             flag_q;
    logic             half_q;
    logic             cnt_fall;
    logic             trig_fall;
    logic             tmr_ovf;
    logic             t1_tick;
    logic             clr_wr;
    logic [NUM_CH-1:0] bit_en;

    assign clr_wr = wr_en && (wr_addr == ADDR_CLR);

    // Configuration writes
    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data);
            for (int b = 0; b < BYTES; b++) begin
                if (wr_addr == 2'(b)) reload_q[b*8 +: 8] <= wr_data;
            end
        end
    end

    baud_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .pin_i(count_pin), .fall_o(cnt_fall)
    );

    baud_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst(rst), .pin_i(trig_pin), .fall_o(trig_fall)
    );

    baud_reload_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst),
        .run_i(ctrl_q.run), .ext_mode_i(ctrl_q.cnt_src), .ext_fall_i(cnt_fall),
        .reload_i(reload_q), .ovf_o(tmr_ovf)
    );

    // Neighbouring timer path: optional halving
    always_ff @(posedge clk) begin
        if (rst)         half_q <= 1'b0;
        else if (t1_ovf) half_q <= ~half_q;
    end
    assign t1_tick = t1_ovf && (ctrl_q.dbl || half_q);

    // One divide-by-16 per direction (0 = receive, 1 = transmit)
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic sel;
        logic tick;
        assign sel  = (ch == 0) ? ctrl_q.rx_sel : ctrl_q.tx_sel;
        assign tick = pick_src(sel, tmr_ovf, t1_tick);
        baud_div #(.BITS(DIV_BITS)) u_div (
            .clk(clk), .rst(rst), .tick_i(tick), .strobe_o(bit_en[ch])
        );
    end

    assign rx_bit_en = bit_en[0];
    assign tx_bit_en = bit_en[1];

    // Sticky trigger flag; a new edge wins over a clear write
    always_ff @(posedge clk) begin
        if (rst)                              flag_q <= 1'b0;
        else if (ctrl_q.trig_en && trig_fall) flag_q <= 1'b1;
        else if (clr_wr)                      flag_q <= 1'b0;
    end
    assign ext_flag = flag_q;

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(ctrl_q.trig_en && trig_fall)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_wr) |=> flag_q); // R10

endmodule

// File: tb/tb_baudgen_top.sv
module tb_baudgen_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       t1_ovf;
    logic       count_pin;
    logic       trig_pin;
    logic       rx_bit_en;
    logic       tx_bit_en;
    logic       ext_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int t1_period = 0;

    localparam logic [7:0] C_RUN = 8'h01, C_SRC = 8'h02, C_RX = 8'h04,
                           C_TX = 8'h08, C_TRIG = 8'h10, C_DBL = 8'h20;

    always #2 clk = ~clk;

    baudgen_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .t1_ovf(t1_ovf), .count_pin(count_pin), .trig_pin(trig_pin),
        .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en), .ext_flag(ext_flag)
    );

    // Neighbouring-timer overflow generator
    initial begin
        int c = 0;
        t1_ovf = 1'b0;
        forever begin
            @(negedge clk);
            if (t1_period > 0) begin
                c = (c + 1) % t1_period;
                t1_ovf = (c == 0);
            end else begin
                c = 0;
                t1_ovf = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int ch);
        return (ch == 0) ? rx_bit_en : tx_bit_en;
    endfunction

    task automatic do_reset();
        t1_period = 0;
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        count_pin = 1'b1; trig_pin = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Measure the spacing between two strobes; also checks one-cycle width (R3)
    task automatic measure(input int ch, input int exp, input string req);
        int n = 0;
        while (!pick(ch) && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
        check(!pick(ch), "R3", int'(pick(ch)), 0);
        n = 1;
        while (!pick(ch) && n < 20000) begin @(negedge clk); n++; end
        check(n == exp, req, n, exp);
    endtask

    task automatic count_pulses(input int ch, input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pick(ch)) cnt++;
        end
    endtask

    task automatic t_reset();
        int p;
        do_reset();
        check(ext_flag == 1'b0, "R11", int'(ext_flag), 0);
        count_pulses(0, 200, p);
        check(p == 0, "R11", p, 0);
    endtask

    task automatic t_rates();
        do_reset();
        wr(2'd0, 8'hC9); wr(2'd1, 8'hFF);
        wr(2'd2, C_RUN | C_RX | C_TX);
        measure(0, 1760, "R12");
        measure(0, 1760, "R2");
        measure(1, 1760, "R4");
        do_reset();
        wr(2'd0, 8'hE5); wr(2'd1, 8'hFF);
        wr(2'd2, C_RUN | C_RX);
        measure(0, 864, "R12");
        do_reset();
        wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
        wr(2'd2, C_RUN | C_RX);
        measure(0, 32 * 16, "R1");
    endtask

    task automatic t_halt();
        int p;
        do_reset();
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        wr(2'd2, C_RX | C_TX);
        count_pulses(0, 300, p);
        check(p == 0, "R7", p, 0);
        wr(2'd2, C_RUN | C_RX);
        measure(0, 32, "R7");
    endtask

    task automatic t_independent();
        do_reset();
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        t1_period = 4;
        wr(2'd2, C_RUN | C_RX | C_DBL);
        measure(0, 32, "R4");
        measure(1, 64, "R5");
    endtask

    task automatic t_double();
        do_reset();
        t1_period = 4;
        wr(2'd2, 8'h00);
        measure(1, 128, "R6");
        measure(0, 128, "R6");
        wr(2'd2, C_DBL);
        measure(1, 64, "R6");
    endtask

    task automatic t_ext();
        int p = 0;
        do_reset();
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        wr(2'd2, C_RUN | C_SRC | C_RX);
        for (int i = 0; i < 32; i++) begin
            count_pin = 1'b0;
            repeat (3) begin @(negedge clk); if (rx_bit_en) p++; end
            count_pin = 1'b1;
            repeat (3) begin @(negedge clk); if (rx_bit_en) p++; end
        end
        repeat (10) begin @(negedge clk); if (rx_bit_en) p++; end
        check(p == 2, "R8", p, 2);
    endtask

    task automatic t_trig();
        do_reset();
        wr(2'd2, 8'h00);
        trig_pin = 1'b0; repeat (8) @(negedge clk); trig_pin = 1'b1;
        repeat (4) @(negedge clk);
        check(ext_flag == 1'b0, "R9", int'(ext_flag), 0);
        wr(2'd2, C_TRIG);
        trig_pin = 1'b0; repeat (8) @(negedge clk); trig_pin = 1'b1;
        check(ext_flag == 1'b1, "R9", int'(ext_flag), 1);
        repeat (50) @(negedge clk);
        check(ext_flag == 1'b1, "R10", int'(ext_flag), 1);
        wr(2'd3, 8'h00);
        check(ext_flag == 1'b0, "R10", int'(ext_flag), 0);
        wr(2'd0, 8'h12);
        check(ext_flag == 1'b0, "R13", int'(ext_flag), 0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        count_pin = 1'b1; trig_pin = 1'b1;
        t_reset();
        t_rates();
        t_halt();
        t_independent();
        t_double();
        t_ext();
        t_trig();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule